// File: doc/BRIEF.md
# Signed Carry-Save Array Multiplier

This block multiplies two signed two's complement operands of N bits each and returns the exact 2N-bit two's complement product. It is purely combinational: the product follows the operands after the settling delay of the array, with no clock, register or handshake. N defaults to 5 and must be at least 3.

The array is a grid of identical full-adder cells. Each partial-product bit is the AND of one multiplicand bit and one multiplier bit. The partial products that pair exactly one sign bit with a non-sign bit carry negative weight. Every signal in the grid has a fixed weight polarity. A bit of negative weight is carried on its wire in complemented form. With that convention, the mixed-sign cell kinds need no gates beyond a plain full adder:

- An all-positive cell.
- A cell with one negative input, whose sum output is negative and whose carry output is positive.
- A cell with two negative inputs, whose carry output is negative and whose sum output is positive.

No correction row and no sign extension are needed. The only extra gates are:

- NAND gates at the negative partial-product positions.
- A constant 1 at the carry input of the final row.
- One inverter on the top product bit.

The multiplier rows reduce in carry-save form, with no carry moving sideways inside a row. A single ripple-carry row then merges the remaining sum and carry vectors into the upper half of the product.

Top module: `smul_array`

## Requirements
- R1: For every pair of operands, `prod` read as signed equals the signed multiplicand times the signed multiplier (exhaustively for N=5).
- R2: `prod[0]` equals `mcand[0] & mplier[0]`.
- R3: If either operand is zero, `prod` is all zeros.
- R4: The most negative value times itself gives +2^(2N-2) (256 for N=5) without overflow, so the top bit `prod[2N-1]` is 0.
- R5: When both operands are non-zero, `prod[2N-1]` equals `mcand[N-1] ^ mplier[N-1]`.
- R6: Multiplying by +1 returns the other operand sign-extended to 2N bits. Multiplying by -1 (all ones) returns its two's complement negation, including -(-2^(N-1)) = +2^(N-1).
- R7: The low half `prod[N-1:0]` equals the low N bits of the unsigned product of the two operand bit patterns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand | input | N | Multiplicand, two's complement |
| mplier | input | N | Multiplier, two's complement |
| prod | output | 2N | Product, two's complement |

## Verification
A cell that is wired with the wrong weight polarity, or a wrong NAND/AND choice at one partial-product position, shifts the result by a fixed power of two. It does so only for operand pairs that set that bit. Such an error therefore shows at `prod` in the same evaluation, but only for a subset of operand patterns. An exhaustive sweep of all operand pairs at N=5 leaves no such subset unvisited. Errors near the sign corner show up mainly as a wrong top bit or a failed most-negative square, so those cases are also checked directly.

// File: rtl/smul_pkg.sv
package smul_pkg;

  // A partial product a_i * x_j has negative weight when exactly one of
  // the two indices addresses a sign bit.
  function automatic bit pp_is_negative(input int i, input int j, input int n);
    return ((i == n - 1) != (j == n - 1));
  endfunction

endpackage

// File: rtl/smul_fa.sv
module smul_fa (
  input  logic in_a,
  input  logic in_b,
  input  logic in_c,
  output logic sum,
  output logic carry
);

  always_comb begin
    sum   = in_a ^ in_b ^ in_c;
    carry = (in_a & in_b) | (in_c & (in_a ^ in_b));
  end

endmodule

// File: rtl/smul_ppgen.sv
module smul_ppgen #(
  parameter int N = 5
) (
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic [N*N-1:0] pp      // row j, column i at index j*N+i
);
  import smul_pkg::*;

  for (genvar j = 0; j < N; j++) begin : g_row
    for (genvar i = 0; i < N; i++) begin : g_col
      if (pp_is_negative(i, j, N)) begin : g_neg
        // negative-weight bit travels complemented
        assign pp[j*N+i] = ~(mcand[i] & mplier[j]);
      end else begin : g_pos
        assign pp[j*N+i] = mcand[i] & mplier[j];
      end
    end
  end

endmodule

// File: rtl/smul_csa_row.sv
module smul_csa_row #(
  parameter int N = 5
) (
  input  logic [N-1:0] pp_row,
  input  logic [N-1:0] sum_in,
  input  logic [N-1:0] carry_in,
  output logic [N-1:0] sum_out,
  output logic [N-1:0] carry_out
);

  for (genvar i = 0; i < N; i++) begin : g_cell
    smul_fa u_fa (
      .in_a  (pp_row[i]),
      .in_b  (sum_in[i]),
      .in_c  (carry_in[i]),
      .sum   (sum_out[i]),
      .carry (carry_out[i])
    );
  end

endmodule

// File: rtl/smul_ripple_row.sv
module smul_ripple_row #(
  parameter int N = 5
) (
  input  logic [N-1:0] sum_vec,
  input  logic [N-1:0] carry_vec,
  input  logic         seed,
  output logic [N-1:0] result
);

  logic [N-1:0] chain;

  assign chain[0] = seed;

  for (genvar k = 0; k < N; k++) begin : g_bit
    if (k < N - 1) begin : g_full
      smul_fa u_fa (
        .in_a  (sum_vec[k]),
        .in_b  (carry_vec[k]),
        .in_c  (chain[k]),
        .sum   (result[k]),
        .carry (chain[k+1])
      );
    end else begin : g_top
      // carry leaving the top column is always zero in value; not formed
      assign result[k] = sum_vec[k] ^ carry_vec[k] ^ chain[k];
    end
  end

endmodule

// File: rtl/smul_array.sv
module smul_array #(
  parameter int N = 5
) (
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic [2*N-1:0] prod
);

  localparam int W = 2 * N;

  logic [N*N-1:0] pp;
  logic [N-1:0]   row_sum   [N];
  logic [N-1:0]   row_carry [N];
  logic [N-1:0]   upper;

  smul_ppgen #(.N(N)) u_ppgen (
    .mcand  (mcand),
    .mplier (mplier),
    .pp     (pp)
  );

  // Row 0 is the first partial product itself; no carries yet.
  assign row_sum[0]   = pp[N-1:0];
  assign row_carry[0] = '0;
  assign prod[0]      = row_sum[0][0];

  for (genvar j = 1; j < N; j++) begin : g_rows
    logic [N-1:0] shifted_sum;
    // sums move one column right; the empty top slot is a positive zero
    assign shifted_sum = {1'b0, row_sum[j-1][N-1:1]};

    smul_csa_row #(.N(N)) u_row (
      .pp_row    (pp[j*N +: N]),
      .sum_in    (shifted_sum),
      .carry_in  (row_carry[j-1]),
      .sum_out   (row_sum[j]),
      .carry_out (row_carry[j])
    );

    assign prod[j] = row_sum[j][0];
  end

  // Final merge: seed is a negative-weight zero (physical 1) so every
  // cell in the chain keeps a positive sum below the top column.
  smul_ripple_row #(.N(N)) u_merge (
    .sum_vec   ({1'b0, row_sum[N-1][N-1:1]}),
    .carry_vec (row_carry[N-1]),
    .seed      (1'b1),
    .result    (upper)
  );

  assign prod[W-2:N] = upper[N-2:0];
  assign prod[W-1]   = ~upper[N-1];   // top column leaves negative-weight form

endmodule

// File: rtl/smul_array_chk.sv
module smul_array_chk #(
  parameter int N = 5
) (
  input logic [N-1:0]   mcand,
  input logic [N-1:0]   mplier,
  input logic [2*N-1:0] prod
);

  localparam int W = 2 * N;

  logic signed [W-1:0] ext_a;
  logic signed [W-1:0] ext_x;
  logic signed [W-1:0] model;
  logic        [W-1:0] raw_u;
  logic                a_zero;
  logic                x_zero;

  always_comb begin
    ext_a  = {{N{mcand[N-1]}}, mcand};
    ext_x  = {{N{mplier[N-1]}}, mplier};
    model  = ext_a * ext_x;
    raw_u  = {{N{1'b0}}, mcand} * {{N{1'b0}}, mplier};
    a_zero = (mcand == '0);
    x_zero = (mplier == '0);
  end

  always_comb begin
    p_signed_product_r1: assert ($signed(prod) == model)
      else $error("R1 product mismatch");
    p_low_bit_r2: assert (prod[0] == (mcand[0] & mplier[0]))
      else $error("R2 low bit mismatch");
    p_zero_operand_r3: assert (!(a_zero || x_zero) || (prod == '0))
      else $error("R3 zero operand gave nonzero product");
    p_sign_bit_r5: assert (a_zero || x_zero || (prod[W-1] == (mcand[N-1] ^ mplier[N-1])))
      else $error("R5 sign bit mismatch");
    p_low_half_r7: assert (prod[N-1:0] == raw_u[N-1:0])
      else $error("R7 low half mismatch");
  end

endmodule

bind smul_array smul_array_chk #(.N(N)) u_chk (
  .mcand  (mcand),
  .mplier (mplier),
  .prod   (prod)
);

// File: tb/sim_smul_array.sv
`timescale 1ns/1ps
module sim_smul_array;

  localparam int N = 5;
  localparam int W = 2 * N;
  localparam int NVEC = 13;

  // {mcand, mplier, expected product}
  localparam logic [N+N+W-1:0] VEC [NVEC] = '{
    {5'h00, 5'h00, 10'h000},   // R3
    {5'h00, 5'h10, 10'h000},   // R3
    {5'h0B, 5'h00, 10'h000},   // R3
    {5'h10, 5'h10, 10'h100},   // R4
    {5'h01, 5'h10, 10'h3F0},   // R6
    {5'h1F, 5'h10, 10'h010},   // R6
    {5'h0F, 5'h0F, 10'h0E1},   // R1
    {5'h0F, 5'h10, 10'h310},   // R1
    {5'h1F, 5'h1F, 10'h001},   // R6
    {5'h03, 5'h1B, 10'h3F1},   // R1
    {5'h07, 5'h09, 10'h03F},   // R1
    {5'h13, 5'h06, 10'h3B2},   // R1
    {5'h0A, 5'h01, 10'h00A}    // R6
  };

  logic         clk;
  logic [N-1:0] mcand;
  logic [N-1:0] mplier;
  logic [W-1:0] prod;
  int checks;
  int errors;
  bit done;

  smul_array #(.N(N)) u0 (
    .mcand  (mcand),
    .mplier (mplier),
    .prod   (prod)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s a=%h x=%h actual=%h expected=%h", req, mcand, mplier, got, exp);
    end
  endtask

  task automatic apply(input logic [N-1:0] a, input logic [N-1:0] x);
    @(negedge clk);
    mcand  = a;
    mplier = x;
    #1;
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done   = 0;
    mcand  = '0;
    mplier = '0;

    // quiescent state: zero operands
    apply('0, '0);
    check("R3_idle", prod, '0);

    // table of directed vectors
    for (int v = 0; v < NVEC; v++) begin
      apply(VEC[v][N+N+W-1 -: N], VEC[v][N+W-1 -: N]);
      check("R1_table", prod, VEC[v][W-1:0]);
    end

    // most negative squared: top bit clear (R4)
    apply(5'h10, 5'h10);
    check("R4_top_bit", {{(W-1){1'b0}}, prod[W-1]}, '0);

    // exhaustive sweep
    for (int a = 0; a < (1 << N); a++) begin
      for (int x = 0; x < (1 << N); x++) begin
        int sa;
        int sx;
        int sp;
        int up;
        apply(N'(a), N'(x));
        sa = (a >= (1 << (N - 1))) ? a - (1 << N) : a;
        sx = (x >= (1 << (N - 1))) ? x - (1 << N) : x;
        sp = sa * sx;
        up = a * x;
        check("R1", prod, W'(sp));
        check("R2", {{(W-1){1'b0}}, prod[0]}, {{(W-1){1'b0}}, 1'(a & x & 1)});
        check("R7", {{N{1'b0}}, prod[N-1:0]}, {{N{1'b0}}, N'(up)});
        if (sa == 0 || sx == 0) begin
          check("R3", prod, '0);
        end else begin
          check("R5", {{(W-1){1'b0}}, prod[W-1]}, {{(W-1){1'b0}}, 1'((sp < 0) ? 1 : 0)});
        end
        if (sx == 1)  check("R6_plus_one", prod, W'(sa));
        if (sx == -1) check("R6_minus_one", prod, W'(-sa));
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule